// File: doc/BRIEF.md
# Program Counter Return Stack

This block keeps the program counter of a small processor inside an eight-entry file of 14-bit addresses. A 3-bit level pointer chooses which entry is the live program counter. A call or restart moves the pointer forward and writes the destination into the newly selected entry. The entry it leaves behind is the return address. A return moves the pointer back, so no memory traffic is needed for subroutine linkage.

The surrounding sequencer presents one control strobe per step: increment, jump, call, return or restart. With it come the 14-bit destination, the current opcode byte and the four condition flags. The block decodes the opcode's condition field and decides whether the transfer happens. One cycle later it reports that decision on `taken_o`, and the sequencer uses it to choose the long or short cycle count of the instruction. When more than one strobe is raised, a fixed priority applies.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pc_o` = 0 and `taken_o` = 0.
- R2: An increment strobe adds one to `pc_o` modulo 2^14, so 0x3FFF becomes 0x0000, and `taken_o` reads 0 afterwards.
- R3: For jump, call and return strobes, opcode bit 2 = 1 means unconditional. Otherwise opcode bits [4:3] select the flag (00 carry, 01 zero, 10 sign, 11 parity), and the transfer is taken when that flag equals opcode bit 5. A taken jump loads `target_i`. A jump that is not taken leaves `pc_o` unchanged.
- R4: A taken call advances the level pointer by one and loads `target_i` as the new `pc_o`. The entry left behind keeps its value. A call that is not taken leaves `pc_o` unchanged.
- R5: A taken return moves the level pointer back by one, and `pc_o` becomes the value held in that entry. A return that is not taken leaves `pc_o` unchanged.
- R6: A restart strobe is always taken. It advances the level pointer and loads the address opcode[5:3]×8 with all upper bits zero.
- R7: The pointer wraps modulo 8 without any signal. An eighth nested call overwrites the oldest entry, and a return from level 0 selects entry 7.
- R8: `taken_o` is registered. In the cycle after a jump, call, return or restart strobe it shows whether the transfer happened. After an increment or an idle cycle it is 0, and after an idle cycle `pc_o` is unchanged.
- R9: When several strobes are high together, only one acts, in the priority order restart, call, return, jump, increment.
- R10: Reset clears only the pointer and entry 0. Entries 1 to 7 keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_i | input | 1 | Increment the program counter |
| jump_i | input | 1 | Jump strobe, condition taken from opcode |
| call_i | input | 1 | Call strobe, condition taken from opcode |
| ret_i | input | 1 | Return strobe, condition taken from opcode |
| restart_i | input | 1 | One-byte call to vector opcode[5:3]×8 |
| opcode_i | input | 8 | Current instruction byte |
| target_i | input | 14 | Destination for jump and call |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_p_i | input | 1 | Parity flag |
| pc_o | output | 14 | Live program counter (selected entry) |
| taken_o | output | 1 | Transfer decision of the previous step |

## Verification
The assertions check on every cycle how each strobe relates to the next `pc_o` and `taken_o`. They cover increment arithmetic, restart vectors, forced taking for unconditional opcodes, a jump or call landing on `target_i` exactly when taken, and stillness after idle or untaken steps. They cannot see which value a return brings back, because that depends on history held in the entry file. Only the bench scenarios show that: nested calls followed by returns, the pointer wrapping past eight levels, and entries surviving reset.

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
  parameter int AW    = 14,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          restart_i,
  input  logic [7:0]    opcode_i,
  input  logic [AW-1:0] target_i,
  input  logic          flag_c_i,
  input  logic          flag_z_i,
  input  logic          flag_s_i,
  input  logic          flag_p_i,
  output logic [AW-1:0] pc_o,
  output logic          taken_o
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] lvl;
  logic [AW-1:0] ent [DEPTH];

  assign pc_o = ent[lvl];

  // flag index follows opcode[4:3]: carry, zero, sign, parity
  wire [3:0] flg    = {flag_p_i, flag_s_i, flag_z_i, flag_c_i};
  wire       cond_ok = opcode_i[2] | (flg[opcode_i[4:3]] == opcode_i[5]);

  wire sel_rst  = restart_i;
  wire sel_call = call_i & ~restart_i;
  wire sel_ret  = ret_i  & ~restart_i & ~call_i;
  wire sel_jmp  = jump_i & ~restart_i & ~call_i & ~ret_i;
  wire sel_inc  = inc_i  & ~restart_i & ~call_i & ~ret_i & ~jump_i;

  wire push     = sel_rst | (sel_call & cond_ok);
  wire pop      = sel_ret & cond_ok;
  wire jmp_go   = sel_jmp & cond_ok;
  wire taken_nx = push | pop | jmp_go;

  wire [PW-1:0] lvl_up = lvl + 1'b1;
  wire [PW-1:0] lvl_dn = lvl - 1'b1;
  wire [AW-1:0] vec    = AW'({opcode_i[5:3], 3'b000});

  logic          wr;
  logic [PW-1:0] wr_idx;
  logic [AW-1:0] wr_dat;

  always_comb begin
    wr     = push | jmp_go | sel_inc;
    wr_idx = push ? lvl_up : lvl;
    if (sel_rst)      wr_dat = vec;
    else if (sel_inc) wr_dat = pc_o + 1'b1;
    else              wr_dat = target_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl     <= '0;
      ent[0]  <= '0;
      taken_o <= 1'b0;
    end else begin
      taken_o <= taken_nx;
      if (push)     lvl <= lvl_up;
      else if (pop) lvl <= lvl_dn;
      if (wr) ent[wr_idx] <= wr_dat;
    end
  end
endmodule

// File: rtl/pc_stack_unit_chk.sv
module pc_stack_unit_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inc_i,
  input logic          jump_i,
  input logic          call_i,
  input logic          ret_i,
  input logic          restart_i,
  input logic [7:0]    opcode_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] pc_o,
  input logic          taken_o
);
  wire any_x = jump_i | call_i | ret_i | restart_i;
  wire idle  = ~any_x & ~inc_i;

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && !taken_o));

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !any_x) |=> (pc_o == $past(pc_o) + 1'b1 && !taken_o));

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !call_i && !ret_i && !restart_i) |=>
      (taken_o ? pc_o == $past(target_i) : pc_o == $past(pc_o)));

  assert_uncond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((jump_i || call_i || ret_i) && opcode_i[2]) |=> taken_o);

  assert_call_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !restart_i) |=>
      (taken_o ? pc_o == $past(target_i) : pc_o == $past(pc_o)));

  assert_ret_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !restart_i) |=> (taken_o || pc_o == $past(pc_o)));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (taken_o && pc_o == AW'({$past(opcode_i[5:3]), 3'b000})));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!taken_o && $stable(pc_o)));
endmodule

bind pc_stack_unit pc_stack_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .jump_i(jump_i),
  .call_i(call_i), .ret_i(ret_i), .restart_i(restart_i),
  .opcode_i(opcode_i), .target_i(target_i), .pc_o(pc_o), .taken_o(taken_o)
);

// File: tb/pc_stack_unit_tb.sv
`timescale 1ns/1ps
module pc_stack_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc_i = 0, jump_i = 0, call_i = 0, ret_i = 0, restart_i = 0;
  logic [7:0]  opcode_i = '0;
  logic [13:0] target_i = '0;
  logic fc = 0, fz = 0, fs = 0, fp = 0;
  logic [13:0] pc_o;
  logic taken_o;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  pc_stack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
    .ret_i(ret_i), .restart_i(restart_i), .opcode_i(opcode_i), .target_i(target_i),
    .flag_c_i(fc), .flag_z_i(fz), .flag_s_i(fs), .flag_p_i(fp),
    .pc_o(pc_o), .taken_o(taken_o)
  );

  // [45:41] {restart,call,ret,jump,inc} [40:33] opcode [32:19] target
  // [18:15] {P,S,Z,C} [14:1] expected pc [0] expected taken
  localparam int NV = 21;
  localparam logic [45:0] VEC [NV] = '{
    {5'b00001, 8'h00, 14'h0000, 4'b0000, 14'h0001, 1'b0},
    {5'b00001, 8'h00, 14'h0000, 4'b0000, 14'h0002, 1'b0},
    {5'b00010, 8'h44, 14'h0100, 4'b0000, 14'h0100, 1'b1},
    {5'b00010, 8'h40, 14'h0AAA, 4'b0001, 14'h0100, 1'b0},
    {5'b00010, 8'h48, 14'h0200, 4'b1101, 14'h0200, 1'b1},
    {5'b00010, 8'h70, 14'h0300, 4'b0100, 14'h0300, 1'b1},
    {5'b00010, 8'h78, 14'h0BBB, 4'b0111, 14'h0300, 1'b0},
    {5'b01000, 8'h62, 14'h1000, 4'b0001, 14'h1000, 1'b1},
    {5'b00001, 8'h00, 14'h0000, 4'b0000, 14'h1001, 1'b0},
    {5'b01000, 8'h4A, 14'h0CCC, 4'b0010, 14'h1001, 1'b0},
    {5'b01000, 8'h46, 14'h2000, 4'b0000, 14'h2000, 1'b1},
    {5'b10000, 8'h2D, 14'h3FFF, 4'b0000, 14'h0028, 1'b1},
    {5'b00100, 8'h23, 14'h0000, 4'b1110, 14'h0028, 1'b0},
    {5'b00100, 8'h07, 14'h0000, 4'b0000, 14'h2000, 1'b1},
    {5'b00100, 8'h1B, 14'h0000, 4'b0111, 14'h1001, 1'b1},
    {5'b00100, 8'h33, 14'h0000, 4'b0100, 14'h0300, 1'b1},
    {5'b00000, 8'h00, 14'h0000, 4'b0000, 14'h0300, 1'b0},
    {5'b01011, 8'h46, 14'h0555, 4'b0000, 14'h0555, 1'b1},
    {5'b11100, 8'h3D, 14'h1234, 4'b0000, 14'h0038, 1'b1},
    {5'b00110, 8'h07, 14'h2222, 4'b0000, 14'h0555, 1'b1},
    {5'b00100, 8'h07, 14'h0000, 4'b0000, 14'h0300, 1'b1}
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] s, input logic [7:0] op,
                      input logic [13:0] tg, input logic [3:0] f);
    @(negedge clk);
    {restart_i, call_i, ret_i, jump_i, inc_i} = s;
    opcode_i = op; target_i = tg; {fp, fs, fz, fc} = f;
    @(posedge clk);
    #1;
    {restart_i, call_i, ret_i, jump_i, inc_i} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1 pc", pc_o, 14'h0);
    check("R1 taken", {13'b0, taken_o}, 14'h0);

    // R3 R4 R5 R6 R8 R9 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][45:41], VEC[i][40:33], VEC[i][32:19], VEC[i][18:15]);
      check($sformatf("R3-6/R8/R9 vec%0d pc", i), pc_o, VEC[i][14:1]);
      check($sformatf("R8 vec%0d taken", i), {13'b0, taken_o}, {13'b0, VEC[i][0]});
    end

    // R2 increment wraps at 14 bits
    step(5'b00010, 8'h44, 14'h3FFF, 4'b0000);
    step(5'b00001, 8'h00, 14'h0000, 4'b0000);
    check("R2 wrap", pc_o, 14'h0000);

    // R7 eight nested calls overwrite entry 0
    do_reset();
    for (int k = 1; k <= 8; k++) step(5'b01000, 8'h46, 14'(k * 16), 4'b0000);
    check("R7 eighth call", pc_o, 14'h0080);
    step(5'b00100, 8'h07, 14'h0, 4'b0000);
    check("R7 return wraps to entry 7", pc_o, 14'h0070);
    step(5'b00100, 8'h07, 14'h0, 4'b0000);
    check("R7 second return", pc_o, 14'h0060);

    // R10 reset keeps entries 1..7; R7 underflow from level 0
    do_reset();
    check("R10 pc after reset", pc_o, 14'h0000);
    step(5'b00100, 8'h07, 14'h0, 4'b0000);
    check("R10 entry 7 retained", pc_o, 14'h0070);
    step(5'b00100, 8'h07, 14'h0, 4'b0000);
    check("R10 entry 6 retained", pc_o, 14'h0060);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule